// File: doc/BRIEF.md
# Shifted-Address Post-Update Load Unit

This execution unit carries out one indexed load with post-update at a time. A decoded operation arrives with its access size, a sign-extension choice, a 3-bit shift amount and two register indices. The values of the base register and the index register come with it. The unit forms the effective address from the base register alone, by shifting it left by the shift amount plus one. It issues one aligned doubleword read over a valid/ready request port and waits for a valid response. It then picks the addressed bytes out of the returned doubleword and zero- or sign-extends them into the target value.

In the same cycle the unit presents the updated base register, which is the pre-update base value plus the index value. The index register is used only for this post-increment and never for the address.

Forms whose base index is zero, or equal to the target index, are rejected. So are accesses that are not naturally aligned for their size. In either case the unit raises a one-cycle flag, makes no memory request and performs no register write.

Top module: `shupd_load_unit`

## Requirements
- R1: The effective address is `ra_val` shifted left by `op_sh`+1 and truncated to 64 bits. `mem_req_addr` carries this address with bits 2..0 cleared.
- R2: On completion `ra_we` is high, `ra_idx` equals the accepted base index, and `ra_data` equals the pre-update `ra_val` plus `rb_val`, modulo 2^64.
- R3: `op_size` encodes 0 = byte, 1 = halfword, 2 = word, 3 = doubleword. The byte at address offset k (the effective address bits 2..0) is `mem_rsp_data[63-8k -: 8]`. Bytes at increasing offsets form the value from its most significant byte downwards. The value lands in the low bits of `rt_data`, and `rt_idx` echoes the target index.
- R4: With `op_signed` = 0, every `rt_data` bit above the loaded field is 0.
- R5: With `op_signed` = 1 and size halfword or word, every `rt_data` bit above the loaded field copies the field's most significant bit. For byte and doubleword, `op_signed` has no effect.
- R6: If the effective address bits 2..0 are not a multiple of the access size in bytes, `misalign` pulses for one cycle, one cycle after acceptance. No memory request is made and neither write enable rises.
- R7: If the base index is 0 or equals the target index, `illegal` pulses for one cycle, one cycle after acceptance. No request is made and no write occurs. `illegal` takes precedence over `misalign`.
- R8: `op_ready` is high only while idle. A request stays valid, with a stable address, until `mem_req_ready`. `done`, `rt_we` and `ra_we` rise together for one cycle, in the cycle after `mem_rsp_valid` is sampled.
- R9: After reset, `op_ready` is 1 and `mem_req_valid`, `rt_we`, `ra_we`, `done`, `illegal` and `misalign` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation accepted when op_valid is high |
| op_size | input | 2 | Access size code |
| op_signed | input | 1 | Sign-extend the loaded value |
| op_sh | input | 3 | Address shift field |
| op_rt_idx | input | 5 | Target register index |
| op_ra_idx | input | 5 | Base register index |
| ra_val | input | 64 | Base register value |
| rb_val | input | 64 | Index register value |
| mem_req_valid | output | 1 | Read request valid |
| mem_req_ready | input | 1 | Memory accepts request |
| mem_req_addr | output | 64 | Doubleword-aligned read address |
| mem_rsp_valid | input | 1 | Read data valid |
| mem_rsp_data | input | 64 | Read doubleword |
| rt_we | output | 1 | Target write enable |
| rt_idx | output | 5 | Target write index |
| rt_data | output | 64 | Target write value |
| ra_we | output | 1 | Base write enable |
| ra_idx | output | 5 | Base write index |
| ra_data | output | 64 | Updated base value |
| done | output | 1 | Operation completed with both writes |
| illegal | output | 1 | Invalid register form rejected |
| misalign | output | 1 | Misaligned access rejected |

## Verification
The effective address always has its low SH+1 bits clear, so most offsets and both kinds of misalignment can only be reached with small shift values. A byte at offset 6 needs SH = 0 with an odd base. A misaligned word needs SH = 0, and a misaligned doubleword needs SH of 0 or 1. The stimulus chooses base values and shift fields for each of these. It also uses SH = 7 with the top base bit set to exercise truncation. The behavioural memory varies its acceptance stall and response latency between operations, which covers a request held across stalls.

// File: rtl/shupd_pkg.sv
package shupd_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE = 2'd0,
    SZ_HALF = 2'd1,
    SZ_WORD = 2'd2,
    SZ_DBL  = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_REQ  = 2'd1,
    ST_WAIT = 2'd2
  } state_e;
endpackage

// File: rtl/shupd_addr_gen.sv
module shupd_addr_gen #(
  parameter int XLEN   = 64,
  parameter int SH_W   = 3,
  parameter int RIDX_W = 5
) (
  input  logic [XLEN-1:0]             ra_val,
  input  logic [SH_W-1:0]             sh,
  input  logic [1:0]                  size,
  input  logic [RIDX_W-1:0]           ra_idx,
  input  logic [RIDX_W-1:0]           rt_idx,
  output logic [XLEN-1:0]             ea,
  output logic [XLEN-1:0]             line_addr,
  output logic [$clog2(XLEN/8)-1:0]   off,
  output logic                        misalign,
  output logic                        illegal
);
  localparam int OFF_W   = $clog2(XLEN/8);
  localparam int SHAMT_W = SH_W + 1;

  logic [SHAMT_W-1:0] shamt;
  logic [OFF_W-1:0]   amask;

  assign shamt     = {1'b0, sh} + SHAMT_W'(1);
  assign ea        = ra_val << shamt;
  assign off       = ea[OFF_W-1:0];
  assign line_addr = {ea[XLEN-1:OFF_W], {OFF_W{1'b0}}};
  assign amask     = ~({OFF_W{1'b1}} << size);
  assign misalign  = |(off & amask);
  assign illegal   = (ra_idx == '0) || (ra_idx == rt_idx);
endmodule

// File: rtl/shupd_extract.sv
module shupd_extract #(
  parameter int XLEN = 64
) (
  input  logic [XLEN-1:0]           data,
  input  logic [$clog2(XLEN/8)-1:0] off,
  input  logic [1:0]                size,
  input  logic                      sgn,
  output logic [XLEN-1:0]           value
);
  localparam int OFF_W = $clog2(XLEN/8);
  localparam int NSZ   = OFF_W + 1;

  logic [XLEN-1:0] shifted;
  logic [XLEN-1:0] cand [NSZ];

  assign shifted = data << {off, 3'b000};

  for (genvar s = 0; s < NSZ; s++) begin : g_sz
    localparam int W       = 8 << s;
    localparam bit CAN_SX  = (s > 0) && (s < NSZ - 1);
    logic [W-1:0] fld;
    logic         fill;
    assign fld  = shifted[XLEN-1 -: W];
    assign fill = CAN_SX ? (sgn & fld[W-1]) : 1'b0;
    if (W == XLEN) begin : g_full
      assign cand[s] = fld;
    end else begin : g_part
      assign cand[s] = {{(XLEN-W){fill}}, fld};
    end
  end

  assign value = cand[size];
endmodule

// File: rtl/shupd_load_unit.sv
module shupd_load_unit #(
  parameter int XLEN   = 64,
  parameter int SH_W   = 3,
  parameter int RIDX_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              op_valid,
  output logic              op_ready,
  input  logic [1:0]        op_size,
  input  logic              op_signed,
  input  logic [SH_W-1:0]   op_sh,
  input  logic [RIDX_W-1:0] op_rt_idx,
  input  logic [RIDX_W-1:0] op_ra_idx,
  input  logic [XLEN-1:0]   ra_val,
  input  logic [XLEN-1:0]   rb_val,
  output logic              mem_req_valid,
  input  logic              mem_req_ready,
  output logic [XLEN-1:0]   mem_req_addr,
  input  logic              mem_rsp_valid,
  input  logic [XLEN-1:0]   mem_rsp_data,
  output logic              rt_we,
  output logic [RIDX_W-1:0] rt_idx,
  output logic [XLEN-1:0]   rt_data,
  output logic              ra_we,
  output logic [RIDX_W-1:0] ra_idx,
  output logic [XLEN-1:0]   ra_data,
  output logic              done,
  output logic              illegal,
  output logic              misalign
);
  import shupd_pkg::*;
  localparam int OFF_W = $clog2(XLEN/8);

  state_e            state;
  logic [XLEN-1:0]   ag_ea, ag_line;
  logic [OFF_W-1:0]  ag_off;
  logic              ag_mis, ag_ill;
  logic [OFF_W-1:0]  off_q;
  logic [1:0]        size_q;
  logic              sgn_q;
  logic [XLEN-1:0]   upd_q;
  logic [XLEN-1:0]   ex_val;

  shupd_addr_gen #(.XLEN(XLEN), .SH_W(SH_W), .RIDX_W(RIDX_W)) u_ag (
    .ra_val(ra_val), .sh(op_sh), .size(op_size), .ra_idx(op_ra_idx),
    .rt_idx(op_rt_idx), .ea(ag_ea), .line_addr(ag_line), .off(ag_off),
    .misalign(ag_mis), .illegal(ag_ill)
  );

  shupd_extract #(.XLEN(XLEN)) u_ex (
    .data(mem_rsp_data), .off(off_q), .size(size_q), .sgn(sgn_q), .value(ex_val)
  );

  assign op_ready      = (state == ST_IDLE);
  assign mem_req_valid = (state == ST_REQ);

  always_ff @(posedge clk) begin
    if (rst) begin
      state        <= ST_IDLE;
      rt_we        <= 1'b0;
      ra_we        <= 1'b0;
      done         <= 1'b0;
      illegal      <= 1'b0;
      misalign     <= 1'b0;
      rt_idx       <= '0;
      ra_idx       <= '0;
      rt_data      <= '0;
      ra_data      <= '0;
      mem_req_addr <= '0;
      off_q        <= '0;
      size_q       <= '0;
      sgn_q        <= 1'b0;
      upd_q        <= '0;
    end else begin
      rt_we    <= 1'b0;
      ra_we    <= 1'b0;
      done     <= 1'b0;
      illegal  <= 1'b0;
      misalign <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (op_valid) begin
            if (ag_ill) begin
              illegal <= 1'b1;
            end else if (ag_mis) begin
              misalign <= 1'b1;
            end else begin
              state        <= ST_REQ;
              mem_req_addr <= ag_line;
              off_q        <= ag_off;
              size_q       <= op_size;
              sgn_q        <= op_signed;
              rt_idx       <= op_rt_idx;
              ra_idx       <= op_ra_idx;
              upd_q        <= ra_val + rb_val;
            end
          end
        end
        ST_REQ: begin
          if (mem_req_ready) state <= ST_WAIT;
        end
        ST_WAIT: begin
          if (mem_rsp_valid) begin
            state   <= ST_IDLE;
            rt_data <= ex_val;
            ra_data <= upd_q;
            rt_we   <= 1'b1;
            ra_we   <= 1'b1;
            done    <= 1'b1;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

  // R8
  done_we_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> (rt_we && ra_we));
  // R8
  req_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)));
  // R8
  busy_chk: assert property (@(posedge clk) disable iff (rst)
    mem_req_valid |-> !op_ready);
  // R8
  rsp_done_chk: assert property (@(posedge clk) disable iff (rst)
    (state == ST_WAIT && mem_rsp_valid) |=> done);
  // R7
  illegal_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    illegal |-> (!rt_we && !ra_we && !mem_req_valid && !misalign));
  // R6
  misalign_nowr_chk: assert property (@(posedge clk) disable iff (rst)
    misalign |-> (!rt_we && !ra_we && !mem_req_valid));
  // R4
  zero_ext_chk: assert property (@(posedge clk) disable iff (rst)
    (rt_we && !sgn_q && size_q == SZ_BYTE) |-> (rt_data[XLEN-1:8] == '0));
endmodule

// File: tb/shupd_load_unit_tb_top.sv
module shupd_load_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        op_valid = 1'b0;
  logic        op_ready;
  logic [1:0]  op_size = '0;
  logic        op_signed = 1'b0;
  logic [2:0]  op_sh = '0;
  logic [4:0]  op_rt_idx = '0;
  logic [4:0]  op_ra_idx = '0;
  logic [63:0] ra_val = '0;
  logic [63:0] rb_val = '0;
  logic        mem_req_valid;
  logic        mem_req_ready = 1'b0;
  logic [63:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [63:0] mem_rsp_data = '0;
  logic        rt_we, ra_we, done, illegal, misalign;
  logic [4:0]  rt_idx, ra_idx;
  logic [63:0] rt_data, ra_data;

  always #5 clk = ~clk;

  shupd_load_unit dut_i (
    .clk(clk), .rst(rst), .op_valid(op_valid), .op_ready(op_ready),
    .op_size(op_size), .op_signed(op_signed), .op_sh(op_sh),
    .op_rt_idx(op_rt_idx), .op_ra_idx(op_ra_idx), .ra_val(ra_val), .rb_val(rb_val),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_addr(mem_req_addr), .mem_rsp_valid(mem_rsp_valid),
    .mem_rsp_data(mem_rsp_data), .rt_we(rt_we), .rt_idx(rt_idx), .rt_data(rt_data),
    .ra_we(ra_we), .ra_idx(ra_idx), .ra_data(ra_data), .done(done),
    .illegal(illegal), .misalign(misalign)
  );

  typedef struct {
    int          kind;
    logic [63:0] rt_d;
    logic [63:0] ra_d;
    logic [4:0]  rt;
    logic [4:0]  ra;
    string       tag;
  } exp_t;

  exp_t        sb[$];
  int          checks = 0;
  int          errors = 0;
  logic [63:0] exp_addr = '0;
  string       exp_tag = "";
  int          stall_cfg = 0;
  int          lat_cfg = 0;
  bit          finished = 1'b0;

  function automatic logic [63:0] memfn(input logic [63:0] a);
    return {a[15:0] ^ 16'hF1E2, a[15:0] ^ 16'h3344, ~a[15:0], a[15:0] ^ 16'h8A05};
  endfunction

  task automatic check(input bit ok, input string req, input logic [63:0] got,
                       input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic [1:0] sz, input logic sg, input logic [2:0] sh,
                       input logic [4:0] rt, input logic [4:0] ra,
                       input logic [63:0] rav, input logic [63:0] rbv, input string tag);
    exp_t        e;
    logic [63:0] ea, d, fld;
    int          off, nb;
    ea  = rav << (int'(sh) + 1);
    off = int'(ea[2:0]);
    nb  = 1 << sz;
    d   = memfn({ea[63:3], 3'b000});
    fld = '0;
    for (int i = 0; i < nb; i++) fld = (fld << 8) | 64'(d[63-8*(off+i) -: 8]);
    if (sg && (sz == 2'd1 || sz == 2'd2) && fld[8*nb-1]) begin
      for (int b = 8*nb; b < 64; b++) fld[b] = 1'b1;
    end
    e.kind = (ra == 5'd0 || ra == rt) ? 1 : ((off % nb) != 0) ? 2 : 0;
    e.rt_d = fld;
    e.ra_d = rav + rbv;
    e.rt   = rt;
    e.ra   = ra;
    e.tag  = tag;
    while (!op_ready) @(negedge clk);
    exp_addr  = {ea[63:3], 3'b000};
    exp_tag   = tag;
    sb.push_back(e);
    op_size   = sz;
    op_signed = sg;
    op_sh     = sh;
    op_rt_idx = rt;
    op_ra_idx = ra;
    ra_val    = rav;
    rb_val    = rbv;
    op_valid  = 1'b1;
    @(negedge clk);
    op_valid  = 1'b0;
    @(negedge clk);
  endtask

  // behavioural memory
  initial begin : memory_model
    bit   pend = 1'b0;
    int   cnt = 0;
    int   stall = 0;
    logic [63:0] paddr = '0;
    forever begin
      @(negedge clk);
      mem_rsp_valid = 1'b0;
      if (pend) begin
        if (cnt == 0) begin
          mem_rsp_valid = 1'b1;
          mem_rsp_data  = memfn(paddr);
          pend = 1'b0;
        end else cnt--;
      end
      if (mem_req_ready) begin
        pend  = 1'b1;
        cnt   = lat_cfg;
        stall = stall_cfg;
        mem_req_ready = 1'b0;
      end else if (mem_req_valid && !pend) begin
        if (stall > 0) stall--;
        else begin
          mem_req_ready = 1'b1;
          paddr = mem_req_addr;
          // R1: aligned request address
          check(mem_req_addr == exp_addr, {"R1 address ", exp_tag}, mem_req_addr, exp_addr);
        end
      end
      if (!mem_req_valid && !pend && !mem_req_ready) stall = stall_cfg;
    end
  end

  // monitor / scoreboard
  initial begin : monitor
    exp_t e;
    int   k;
    forever begin
      @(negedge clk);
      if (!rst && (done || illegal || misalign)) begin
        k = done ? 0 : (illegal ? 1 : 2);
        if (sb.size() == 0) begin
          check(1'b0, "R8 unexpected result", 64'(k), 64'hFFFF);
        end else begin
          e = sb.pop_front();
          check(k == e.kind, {"R6/R7 result kind ", e.tag}, 64'(k), 64'(e.kind));
          if (e.kind == 0) begin
            check(rt_data == e.rt_d, {"R3 R4 R5 rt_data ", e.tag}, rt_data, e.rt_d);
            check(ra_data == e.ra_d, {"R2 ra_data ", e.tag}, ra_data, e.ra_d);
            check(rt_idx == e.rt && ra_idx == e.ra, {"R2 R3 indices ", e.tag},
                  {rt_idx, ra_idx}, {e.rt, e.ra});
            check(rt_we && ra_we, {"R8 write enables ", e.tag}, {rt_we, ra_we}, 2'b11);
          end else begin
            check(!rt_we && !ra_we && !mem_req_valid && !(illegal && misalign),
                  {"R6 R7 no side effects ", e.tag},
                  {rt_we, ra_we, mem_req_valid, illegal, misalign}, {3'b000, k == 1, k == 2});
          end
        end
      end
    end
  end

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : driver
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9
    check(op_ready && !mem_req_valid && !rt_we && !ra_we && !done && !illegal && !misalign,
          "R9 reset state", {op_ready, mem_req_valid, rt_we, ra_we, done, illegal, misalign},
          7'b1000000);
    // R3 R4 byte at offset 6
    issue(2'd0, 1'b0, 3'd0, 5'd3, 5'd4, 64'h0000_0000_0000_1003, 64'd16, "R3 byte off6");
    // R5 byte with signed set is still zero-extended
    issue(2'd0, 1'b1, 3'd2, 5'd5, 5'd6, 64'h0000_0000_0000_0010, 64'd1, "R5 byte signed ignored");
    // R4 halfword zero, offset 2
    stall_cfg = 2; lat_cfg = 1;
    issue(2'd1, 1'b0, 3'd0, 5'd7, 5'd8, 64'h0000_0000_0000_0201, 64'd2, "R4 half zero");
    // R5 halfword algebraic negative (offset 0) and positive (offset 2)
    issue(2'd1, 1'b1, 3'd1, 5'd9, 5'd10, 64'h0000_0000_0000_0040, 64'd8, "R5 half neg");
    stall_cfg = 0; lat_cfg = 2;
    issue(2'd1, 1'b1, 3'd0, 5'd9, 5'd10, 64'h0000_0000_0000_0041, 64'd8, "R5 half pos");
    // word zero / algebraic at offset 4 and 0
    issue(2'd2, 1'b0, 3'd1, 5'd11, 5'd12, 64'h0000_0000_0000_0301, 64'd4, "R4 word zero");
    issue(2'd2, 1'b1, 3'd0, 5'd11, 5'd12, 64'h0000_0000_0000_0502, 64'd4, "R5 word alg off4");
    issue(2'd2, 1'b1, 3'd2, 5'd13, 5'd14, 64'h0000_0000_0000_0700, 64'd4, "R5 word alg off0");
    // R5 doubleword with signed set
    stall_cfg = 1; lat_cfg = 0;
    issue(2'd3, 1'b1, 3'd2, 5'd15, 5'd16, 64'h0123_0000_0000_0abc, 64'hFF, "R5 dword");
    // R1 truncation at the largest shift; R2 wraparound of the update
    issue(2'd3, 1'b0, 3'd7, 5'd17, 5'd18, 64'h8000_0000_0000_0001, 64'h8000_0000_0000_0000,
          "R1 R2 trunc wrap");
    // R6 misaligned word and doubleword
    issue(2'd2, 1'b0, 3'd0, 5'd19, 5'd20, 64'h0000_0000_0000_0001, 64'd1, "R6 word mis");
    issue(2'd3, 1'b0, 3'd1, 5'd19, 5'd20, 64'h0000_0000_0000_0001, 64'd1, "R6 dword mis");
    // R7 illegal forms, including one that is also misaligned
    issue(2'd1, 1'b0, 3'd0, 5'd2, 5'd0, 64'h0000_0000_0000_0008, 64'd1, "R7 ra zero");
    issue(2'd1, 1'b0, 3'd0, 5'd9, 5'd9, 64'h0000_0000_0000_0008, 64'd1, "R7 ra eq rt");
    issue(2'd3, 1'b0, 3'd0, 5'd9, 5'd9, 64'h0000_0000_0000_0001, 64'd1, "R7 precedence");
    // R8 back-to-back after error
    stall_cfg = 3; lat_cfg = 1;
    issue(2'd2, 1'b0, 3'd2, 5'd21, 5'd22, 64'h0000_0000_0000_1234, 64'd7, "R8 after error");
    while (sb.size() != 0) @(negedge clk);
    repeat (4) @(negedge clk);
    finished = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule